// File: doc/BRIEF.md
# Saturating Wide-Dividend Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles and returns a quotient clamped to the single-width range. The dividend is formed by placing a 32-bit high-word register above a 32-bit source operand. The divisor is either a 32-bit register operand or a 13-bit signed immediate that is sign-extended to 32 bits. The division runs in unsigned or signed mode. In signed mode the quotient is truncated toward zero.

The quotient is delivered as a 64-bit value. In unsigned mode it is zero-extended and in signed mode it is sign-extended. A condition-code byte comes with it and is derived from that single result. The byte holds a 32-bit flag group in bits 3..0 and a 64-bit flag group in bits 7..4. When the true quotient does not fit in 32 bits, it is replaced by the nearest representable value and the 32-bit overflow flag is raised.

A pipeline controller starts an operation with a one-cycle `start` pulse. It then waits for the one-cycle `done` pulse. A zero divisor never enters the iterative engine. It completes on the next cycle and is reported through `div_zero` only. Trap handling belongs to the caller.

Top module: `sat_divider`

## Requirements
- R1: The dividend is `{y_hi, src_lo}` (y_hi in bits 63..32). In unsigned mode (`signed_mode`=0) a quotient that fits in 32 bits is returned exactly, zero-extended to 64 bits, with flag bit 1 clear.
- R2: In unsigned mode a quotient above 0xFFFFFFFF is returned as 0x00000000_FFFFFFFF with flag bit 1 (32-bit overflow) set. 0xFFFFFFFF itself is not clamped.
- R3: In signed mode (`signed_mode`=1) the dividend is taken as a 64-bit two's-complement value and the divisor as 32-bit two's-complement. The quotient is truncated toward zero and sign-extended to 64 bits.
- R4: In signed mode a quotient above 2^31-1 is returned as 0x00000000_7FFFFFFF with flag bit 1 set. An exact 2^31-1 is not clamped.
- R5: In signed mode a quotient below -2^31 is returned as 0xFFFFFFFF_80000000 with flag bit 1 set. An exact -2^31 is not clamped and leaves bit 1 clear.
- R6: The flag bit positions are as follows. Bit 3 is result bit 31 and bit 2 is set when result bits 31..0 are all zero. Bit 7 is result bit 63 and bit 6 is set when all 64 result bits are zero. Bits 0, 4 and 5 are always zero.
- R7: When `use_imm`=1 the divisor is `imm13` sign-extended to 32 bits and `rs2_val` is ignored. When `use_imm`=0 the divisor is `rs2_val`.
- R8: A `start` accepted while idle with a nonzero divisor raises `busy` from the next cycle. `busy` falls in the same cycle that `done` pulses high for exactly one cycle, and `result` and `flags` are updated then. A `start` while `busy` is ignored.
- R9: A `start` with a zero divisor gives `done`=1 and `div_zero`=1 on the next cycle, with `busy` staying low. `result` and `flags` keep their previous values. The next accepted nonzero-divisor `start` clears `div_zero`.
- R10: After reset, `busy`, `done`, `div_zero`, `result` and `flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1 = two's-complement divide, 0 = unsigned |
| use_imm | input | 1 | 1 = divisor from imm13, 0 = from rs2_val |
| y_hi | input | 32 | Upper half of the dividend |
| src_lo | input | 32 | Lower half of the dividend |
| rs2_val | input | 32 | Register divisor |
| imm13 | input | 13 | Signed immediate divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last accepted operation had a zero divisor |
| result | output | 64 | Clamped, extended quotient |
| flags | output | 8 | Condition-code byte |

## Verification
The vector table covers the following cases:
- Small exact quotients in both modes, which separate unsigned from signed handling.
- All four sign combinations of dividend and divisor, which expose a wrong sign fix-up or rounding direction.
- Quotients sitting exactly on each clamp limit and one step past it: 0xFFFFFFFF, 2^32, 2^31-1, 2^31, -2^31 and -2^32. These separate an off-by-one comparison from a correct clamp.
- The most negative 64-bit dividend divided by minus one, which tests magnitude handling at the extreme.
- Immediate divisors of minus one and minus three, which show whether the 13-bit value is sign-extended and whether the register operand leaks through.

Directed sequences then check the following:
- The zero-divisor path, using both the register and the immediate source.
- A second `start` issued mid-operation, which must be ignored.
- Clearing of `div_zero`.

// File: rtl/div_pkg.sv
package div_pkg;
  // Condition-code byte positions; a flag consumer decodes these.
  localparam int FLG_C32 = 0;
  localparam int FLG_V32 = 1;
  localparam int FLG_Z32 = 2;
  localparam int FLG_N32 = 3;
  localparam int FLG_C64 = 4;
  localparam int FLG_V64 = 5;
  localparam int FLG_Z64 = 6;
  localparam int FLG_N64 = 7;
  localparam int FLG_W   = 8;

  typedef struct packed {
    logic [63:0]      value;
    logic [FLG_W-1:0] flags;
  } div_out_t;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int HALF_W = 32
) (
  input  logic                signed_mode,
  input  logic [HALF_W-1:0]   y_hi,
  input  logic [HALF_W-1:0]   src_lo,
  input  logic [HALF_W-1:0]   dvs_raw,
  output logic [2*HALF_W-1:0] dvd_mag,
  output logic [HALF_W-1:0]   dvs_mag,
  output logic                neg_q
);
  localparam int DW = 2*HALF_W;

  logic [DW-1:0] dvd;
  logic          dvd_neg, dvs_neg;

  always_comb begin
    dvd     = {y_hi, src_lo};
    dvd_neg = signed_mode & dvd[DW-1];
    dvs_neg = signed_mode & dvs_raw[HALF_W-1];
    dvd_mag = dvd_neg ? (~dvd + 1'b1) : dvd;
    dvs_mag = dvs_neg ? (~dvs_raw + 1'b1) : dvs_raw;
    neg_q   = dvd_neg ^ dvs_neg;
  end
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DVD_W-1:0] dvd,
  input  logic [DVS_W-1:0] dvs,
  output logic             busy,
  output logic             fin,
  output logic [DVD_W-1:0] quo
);
  localparam int CNT_W = $clog2(DVD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic [DVS_W-1:0] rem, dv;
  logic [DVD_W-1:0] q;
  logic [CNT_W-1:0] cnt;
  logic [DVS_W:0]   shifted, trial;

  always_comb begin
    shifted = {rem, q[DVD_W-1]};
    trial   = shifted - {1'b0, dv};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      dv   <= '0;
      q    <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load && !busy) begin
        rem  <= '0;
        dv   <= dvs;
        q    <= dvd;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (!trial[DVS_W]) begin
          rem <= trial[DVS_W-1:0];
          q   <= {q[DVD_W-2:0], 1'b1};
        end else begin
          rem <= shifted[DVS_W-1:0];
          q   <= {q[DVD_W-2:0], 1'b0};
        end
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quo = q;

  // Partial remainder stays below the divisor during every step (R1).
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rem < dv));
endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter int HALF_W = 32
) (
  input  logic                 signed_mode,
  input  logic                 neg_q,
  input  logic [2*HALF_W-1:0]  q_mag,
  output div_pkg::div_out_t    out
);
  import div_pkg::*;
  localparam int DW = 2*HALF_W;
  localparam logic [DW-1:0] U_SAT   = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [DW-1:0] POS_LIM = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MAG = {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [DW-1:0] NEG_SAT = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

  logic [DW-1:0] val;
  logic          sat;

  always_comb begin
    sat = 1'b0;
    val = q_mag;
    if (!signed_mode) begin
      if (|q_mag[DW-1:HALF_W]) begin
        sat = 1'b1;
        val = U_SAT;
      end
    end else if (!neg_q) begin
      if (q_mag > POS_LIM) begin
        sat = 1'b1;
        val = POS_LIM;
      end
    end else begin
      if (q_mag > NEG_MAG) begin
        sat = 1'b1;
        val = NEG_SAT;
      end else begin
        val = ~q_mag + 1'b1;
      end
    end
    out.value            = val;
    out.flags            = '0;
    out.flags[FLG_V32]   = sat;
    out.flags[FLG_N32]   = val[HALF_W-1];
    out.flags[FLG_Z32]   = (val[HALF_W-1:0] == '0);
    out.flags[FLG_N64]   = val[DW-1];
    out.flags[FLG_Z64]   = (val == '0);
  end
endmodule

// File: rtl/sat_divider.sv
module sat_divider #(
  parameter int HALF_W = 32,
  parameter int IMM_W  = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                signed_mode,
  input  logic                use_imm,
  input  logic [HALF_W-1:0]   y_hi,
  input  logic [HALF_W-1:0]   src_lo,
  input  logic [HALF_W-1:0]   rs2_val,
  input  logic [IMM_W-1:0]    imm13,
  output logic                busy,
  output logic                done,
  output logic                div_zero,
  output logic [2*HALF_W-1:0] result,
  output logic [7:0]          flags
);
  import div_pkg::*;
  localparam int DW = 2*HALF_W;

  logic [HALF_W-1:0] dvs_raw, dvs_mag;
  logic [DW-1:0]     dvd_mag, quo;
  logic              neg_now, dvs_zero, accept;
  logic              core_busy, core_fin;
  logic              neg_r, sgn_r;
  div_out_t          fixed;

  always_comb begin
    dvs_raw  = use_imm ? {{(HALF_W-IMM_W){imm13[IMM_W-1]}}, imm13} : rs2_val;
    dvs_zero = (dvs_raw == '0);
    accept   = start && !busy;
  end

  div_prep #(.HALF_W(HALF_W)) u_prep (
    .signed_mode(signed_mode), .y_hi(y_hi), .src_lo(src_lo),
    .dvs_raw(dvs_raw), .dvd_mag(dvd_mag), .dvs_mag(dvs_mag), .neg_q(neg_now)
  );

  div_core #(.DVD_W(DW), .DVS_W(HALF_W)) u_core (
    .clk(clk), .rst(rst), .load(accept && !dvs_zero),
    .dvd(dvd_mag), .dvs(dvs_mag),
    .busy(core_busy), .fin(core_fin), .quo(quo)
  );

  div_fix #(.HALF_W(HALF_W)) u_fix (
    .signed_mode(sgn_r), .neg_q(neg_r), .q_mag(quo), .out(fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      div_zero <= 1'b0;
      result   <= '0;
      flags    <= '0;
      neg_r    <= 1'b0;
      sgn_r    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        div_zero <= dvs_zero;
        if (dvs_zero) begin
          done <= 1'b1;
        end else begin
          busy  <= 1'b1;
          neg_r <= neg_now;
          sgn_r <= signed_mode;
        end
      end
      if (core_fin) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= fixed.value;
        flags  <= fixed.flags;
      end
    end
  end

  // R8: completion is a single-cycle pulse, never overlapping busy.
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R8: the engine only runs while the block reports busy.
  assert_core_in_busy_R8: assert property (@(posedge clk) disable iff (rst)
    core_busy |-> busy);
  // R9: zero divisor completes next cycle and leaves the result alone.
  assert_zero_fast_R9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && dvs_zero) |=> (done && div_zero && !busy
                                      && $stable(result) && $stable(flags)));
  // R6: carry and 64-bit overflow bits never set.
  assert_carry_clear_R6: assert property (@(posedge clk) disable iff (rst)
    !flags[FLG_C32] && !flags[FLG_C64] && !flags[FLG_V64]);
  // R2/R4/R5: an overflow flag only accompanies a clamp value.
  assert_sat_value_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero && flags[FLG_V32]) |->
      (result == 64'h0000_0000_FFFF_FFFF || result == 64'h0000_0000_7FFF_FFFF
       || result == 64'hFFFF_FFFF_8000_0000));
endmodule

// File: tb/sim_sat_divider.sv
module sim_sat_divider;
  logic        clk = 1'b0;
  logic        rst;
  logic        start, signed_mode, use_imm;
  logic [31:0] y_hi, src_lo, rs2_val;
  logic [12:0] imm13;
  logic        busy, done, div_zero;
  logic [63:0] result;
  logic [7:0]  flags;

  int nchecks = 0;
  int nerrors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sat_divider u0 (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .use_imm(use_imm), .y_hi(y_hi), .src_lo(src_lo), .rs2_val(rs2_val),
    .imm13(imm13), .busy(busy), .done(done), .div_zero(div_zero),
    .result(result), .flags(flags)
  );

  // {signed, use_imm, y_hi, src_lo, rs2_val, imm13, expected result, expected flags}
  localparam int NV = 15;
  localparam logic [182:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'h0000_0000, 32'd100,       32'd7,         13'h0000, 64'h0000_0000_0000_000E, 8'h00},
    {1'b0, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'd2,         13'h0000, 64'h0000_0000_8000_0000, 8'h08},
    {1'b0, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'd1,         13'h0000, 64'h0000_0000_FFFF_FFFF, 8'h0A},
    {1'b0, 1'b0, 32'h0000_0000, 32'd5,         32'd10,        13'h0000, 64'h0000_0000_0000_0000, 8'h44},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7,         13'h0000, 64'hFFFF_FFFF_FFFF_FFF2, 8'h88},
    {1'b1, 1'b0, 32'h0000_0000, 32'd100,       32'hFFFF_FFF9, 13'h0000, 64'hFFFF_FFFF_FFFF_FFF2, 8'h88},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'hFFFF_FFF9, 13'h0000, 64'h0000_0000_0000_000E, 8'h00},
    {1'b1, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'd1,         13'h0000, 64'h0000_0000_7FFF_FFFF, 8'h02},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'd1,         13'h0000, 64'hFFFF_FFFF_8000_0000, 8'h8A},
    {1'b1, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1,         13'h0000, 64'hFFFF_FFFF_8000_0000, 8'h88},
    {1'b1, 1'b0, 32'h0000_0000, 32'h8000_0000, 32'd1,         13'h0000, 64'h0000_0000_7FFF_FFFF, 8'h02},
    {1'b0, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 32'd3,         13'h1FFF, 64'h0000_0000_0000_0001, 8'h00},
    {1'b1, 1'b1, 32'h0000_0000, 32'd9,         32'd0,         13'h1FFD, 64'hFFFF_FFFF_FFFF_FFFD, 8'h88},
    {1'b1, 1'b0, 32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 13'h0000, 64'h0000_0000_7FFF_FFFF, 8'h02},
    {1'b0, 1'b0, 32'h0000_0007, 32'hFFFF_FFFF, 32'd8,         13'h0000, 64'h0000_0000_FFFF_FFFF, 8'h08}
  };
  localparam string TAG [NV] = '{"R1", "R1", "R2", "R6", "R3", "R3", "R3", "R4",
                                 "R5", "R5", "R4", "R7", "R7", "R4", "R2"};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic im, input logic [31:0] y,
                       input logic [31:0] lo, input logic [31:0] r2, input logic [12:0] i13);
    signed_mode = s; use_imm = im; y_hi = y; src_lo = lo; rs2_val = r2; imm13 = i13;
    start = 1'b1;
  endtask

  // Wait at negedges until done, return cycles waited.
  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nerrors++;
      nchecks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1'b1; start = 1'b0; signed_mode = 1'b0; use_imm = 1'b0;
    y_hi = '0; src_lo = '0; rs2_val = '0; imm13 = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy", {63'd0, busy}, 64'd0);
    chk("R10 done", {63'd0, done}, 64'd0);
    chk("R10 div_zero", {63'd0, div_zero}, 64'd0);
    chk("R10 result", result, 64'd0);
    chk("R10 flags", {56'd0, flags}, 64'd0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][182], VEC[k][181], VEC[k][180:149], VEC[k][148:117],
            VEC[k][116:85], VEC[k][84:72]);
      @(negedge clk);
      start = 1'b0;
      chk({TAG[k], " busy after start"}, {63'd0, busy}, 64'd1);
      wait_done(n);
      chk({TAG[k], " result"}, result, VEC[k][71:8]);
      chk({TAG[k], " flags"}, {56'd0, flags}, {56'd0, VEC[k][7:0]});
      chk({TAG[k], " no div_zero"}, {63'd0, div_zero}, 64'd0);
      @(negedge clk);
      chk("R8 done single cycle", {63'd0, done}, 64'd0);
    end

    // R8: start while busy is ignored; done is one pulse, busy falls with it
    drive(1'b0, 1'b0, 32'd0, 32'd100, 32'd7, 13'd0);
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    drive(1'b0, 1'b0, 32'd0, 32'd50, 32'd5, 13'd0);
    @(negedge clk);
    start = 1'b0;
    chk("R8 still busy", {63'd0, busy}, 64'd1);
    wait_done(n);
    chk("R8 busy low at done", {63'd0, busy}, 64'd0);
    chk("R8 ignored restart result", result, 64'd14);
    @(negedge clk);
    chk("R8 no second completion", {63'd0, done}, 64'd0);
    repeat (70) @(negedge clk);
    chk("R8 no late completion", result, 64'd14);
    chk("R8 idle", {63'd0, busy}, 64'd0);

    // R9: zero register divisor
    drive(1'b1, 1'b0, 32'h1234, 32'h5678, 32'd0, 13'h0005);
    @(negedge clk);
    start = 1'b0;
    chk("R9 done next cycle", {63'd0, done}, 64'd1);
    chk("R9 div_zero set", {63'd0, div_zero}, 64'd1);
    chk("R9 busy stays low", {63'd0, busy}, 64'd0);
    chk("R9 result kept", result, 64'd14);
    chk("R9 flags kept", {56'd0, flags}, 64'd0);
    @(negedge clk);
    chk("R9 done pulse ends", {63'd0, done}, 64'd0);

    // R9/R7: zero immediate divisor while register is nonzero
    drive(1'b0, 1'b1, 32'h0, 32'd77, 32'd5, 13'h0000);
    @(negedge clk);
    start = 1'b0;
    chk("R7 imm zero selected", {63'd0, div_zero}, 64'd1);
    chk("R9 imm zero done", {63'd0, done}, 64'd1);
    chk("R9 imm zero result kept", result, 64'd14);

    // R9: next normal start clears div_zero
    drive(1'b0, 1'b0, 32'h0, 32'd81, 32'd9, 13'h0000);
    @(negedge clk);
    start = 1'b0;
    chk("R9 div_zero cleared", {63'd0, div_zero}, 64'd0);
    wait_done(n);
    chk("R1 after zero path", result, 64'd9);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
    $finish;
  end
endmodule